// File: doc/BRIEF.md
# Write-Protected Two-Level Pad Function Register Bank

This block is the configuration store behind a chip's pad multiplexer. Software reaches it over a simple 32-bit register bus with single-cycle access. The bank holds one first-level word and one second-level word for each pad, plus two selectors that pick the source of the two management-data (MDIO) channels. From these words it drives, for every pad, a resolved function number, the pull setting, the drive-strength code and a high-impedance flag. The pad cells use these outputs directly.

The 4 KiB window at parameter `BASE` is split into two halves. The first-level half sits at offsets 0x000-0x7FF and the second-level half at 0x800-0xFFF. Each half has pad words at `4*pad` and a protect register at half-offset 0x400. The second half also has its two MDIO selectors at 0xC04 (channel 0) and 0xC08 (channel 1). Each half has its own lock, built as a two-state machine with the states LOCKED and OPEN. The transition KEY_OPEN, from LOCKED to OPEN, fires on a write to that half's protect register whose data equals the register's own bus address with bit 0 set. The transition KEY_CLOSE, from OPEN to LOCKED, fires on the same address with bit 0 clear. Every other write leaves the state where it is.

A first-level function code of 0xF hands the choice of function to the pad's second-level word. The resolved number is then 10 plus the second-level value.

Top module: `pmx_protect_bank`

## Requirements
- R1: After reset both halves are LOCKED. Every pad word and MDIO selector is 0, so every pad shows function 0, pull 0, drive 0 and high-impedance 1, and bus_ready and bus_err are 0.
- R2: A write to a protect register at address K (K = BASE+0x400 for the first half, BASE+0xC00 for the second) unlocks that half when the data is {K[31:1],1}, and locks it when the data is {K[31:1],0}.
- R3: A protect write whose data bits 31:1 differ from K[31:1] leaves the lock state unchanged. A write whose address lies outside the window at BASE changes nothing in this bank.
- R4: A write to a pad word or an MDIO selector while its half is LOCKED stores nothing. It raises bus_err for exactly the response cycle, together with bus_ready.
- R5: bus_ready is high in the cycle after each cycle with bus_sel high, and low otherwise. bus_rdata carries the read value in that same cycle.
- R6: A first-level word keeps bits 3:0 (function code), 9:8 (pull) and 11:10 (drive code). It reads back with all other bits 0. A second-level word keeps bits 5:0.
- R7: The resolved function on pad_func (7 bits per pad) follows these rules: first-level codes 0-9 pass through unchanged; code 0xF with a second-level value of 0-61 gives 10 plus that value; codes 10-14, and code 0xF with a second-level value of 62 or 63, give 127.
- R8: pad_hiz is 1 exactly when the first-level code is 0, or when it is 0xF and the second-level value is 0.
- R9: pad_pull and pad_drive (2 bits per pad) carry bits 9:8 and 11:10 of the pad's first-level word. Pull code 0 means none, 1 means up and 3 means down. Drive codes 0 to 3 mean 4, 6, 8 and 12 mA.
- R10: The MDIO selectors keep 3 bits each and read back with the upper bits 0. Channel 0 drives mdio_sel[2:0] and channel 1 drives mdio_sel[5:3]. Writes to them are gated by the second half's lock.
- R11: A protect register reads as {K[31:1], 1 if OPEN else 0}. Unused offsets read as 0, including pad slots at or above NPADS and any address with bits 1:0 nonzero.
- R12: The two halves lock independently. A LOCKED first half does not block writes to an OPEN second half, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Response cycle marker |
| bus_err | output | 1 | Write refused because the half is locked |
| pad_func | output | 7*NPADS | Resolved function number per pad |
| pad_pull | output | 2*NPADS | Pull code per pad |
| pad_drive | output | 2*NPADS | Drive-strength code per pad |
| pad_hiz | output | NPADS | High-impedance flag per pad |
| mdio_sel | output | 6 | MDIO source select, channel 1 in bits 5:3 |

## Verification
The assertions check the following on every cycle: the response timing, that bus_err never appears without bus_ready, that a lock opens only in the cycle after its exact key write, that no pad output or MDIO selector moves while both halves are locked, and that pad 0's high-impedance flag agrees with its resolved function. The bench scenarios show the rest. These are the actual values stored and read back, the mapping of escape codes and out-of-range second-level values, the rejection of keys with wrong upper bits at two different base addresses, and the independence of the two locks under random sequences of lock, unlock and write operations.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
    localparam int          FUNC_W     = 7;
    localparam logic [3:0]  L1_ESCAPE  = 4'hF;
    localparam logic [3:0]  L1_LAST    = 4'd9;
    localparam logic [5:0]  L2_LAST    = 6'd61;
    localparam logic [6:0]  L2_BIAS    = 7'd10;
    localparam logic [6:0]  FUNC_NONE  = 7'h7F;

    typedef struct packed {
        logic [1:0] drive;
        logic [1:0] pull;
        logic [3:0] code;
    } l1_cfg_t;

    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_t;
endpackage

// File: rtl/pmx_lock_fsm.sv
module pmx_lock_fsm #(
    parameter logic [31:0] KEY = 32'h0000_0400
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [31:0] key_data,
    output logic        is_open
);
    import pmx_pkg::*;

    lock_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (key_wr && key_data == {KEY[31:1], 1'b1}) state_d = LK_OPEN;
            LK_OPEN:   if (key_wr && key_data == {KEY[31:1], 1'b0}) state_d = LK_LOCKED;
            default:   state_d = LK_LOCKED;
        endcase
    end

    always_comb is_open = (state_q == LK_OPEN);
endmodule

// File: rtl/pmx_pad_slot.sv
module pmx_pad_slot (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_l1,
    input  logic                   wr_l2,
    input  pmx_pkg::l1_cfg_t       wd_l1,
    input  logic [5:0]             wd_l2,
    output pmx_pkg::l1_cfg_t       l1_q,
    output logic [5:0]             l2_q,
    output logic [pmx_pkg::FUNC_W-1:0] func,
    output logic                   hiz
);
    import pmx_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l1_q <= '0;
            l2_q <= '0;
        end else begin
            if (wr_l1) l1_q <= wd_l1;
            if (wr_l2) l2_q <= wd_l2;
        end
    end

    always_comb begin
        if (l1_q.code <= L1_LAST)
            func = {3'b000, l1_q.code};
        else if (l1_q.code == L1_ESCAPE && l2_q <= L2_LAST)
            func = {1'b0, l2_q} + L2_BIAS;
        else
            func = FUNC_NONE;
        hiz = (l1_q.code == 4'd0) || (l1_q.code == L1_ESCAPE && l2_q == 6'd0);
    end
endmodule

// File: rtl/pmx_protect_bank.sv
module pmx_protect_bank #(
    parameter logic [31:0] BASE  = 32'h4000_0000,
    parameter int          NPADS = 170
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [31:0]         bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_ready,
    output logic                bus_err,
    output logic [7*NPADS-1:0]  pad_func,
    output logic [2*NPADS-1:0]  pad_pull,
    output logic [2*NPADS-1:0]  pad_drive,
    output logic [NPADS-1:0]    pad_hiz,
    output logic [5:0]          mdio_sel
);
    import pmx_pkg::*;

    localparam int          IDX_W    = 8;
    localparam int          NBANKS   = 2;
    localparam logic [31:0] HALF_SPAN = 32'h0000_0800;
    localparam logic [31:0] PROT_OFF  = 32'h0000_0400;

    logic [NBANKS-1:0] bank_open;
    logic [NBANKS-1:0] key_wr;

    logic             hit, wr, bank, in_pads, is_prot, is_mdio, lock_err;
    logic [IDX_W-1:0] idx;
    logic [31:0]      rd_val;
    logic [2:0]       mdio_q [2];

    l1_cfg_t          l1_q  [NPADS];
    logic [5:0]       l2_q  [NPADS];
    logic [FUNC_W-1:0] func [NPADS];
    logic             hiz_w [NPADS];

    always_comb begin
        hit     = bus_sel && (bus_addr[31:12] == BASE[31:12]) && (bus_addr[1:0] == 2'b00);
        wr      = hit && bus_we;
        bank    = bus_addr[11];
        idx     = bus_addr[9:2];
        in_pads = !bus_addr[10] && (32'(idx) < NPADS);
        is_prot = bus_addr[10] && (idx == 8'd0);
        is_mdio = bank && bus_addr[10] && (idx == 8'd1 || idx == 8'd2);
        lock_err = wr && (in_pads || is_mdio) && !bank_open[bank];
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_lock
        localparam logic [31:0] KEY = BASE + HALF_SPAN * b + PROT_OFF;
        assign key_wr[b] = wr && is_prot && (bank == b[0]);
        pmx_lock_fsm #(.KEY(KEY)) u_lock (
            .clk      (clk),
            .rst_n    (rst_n),
            .key_wr   (key_wr[b]),
            .key_data (bus_wdata),
            .is_open  (bank_open[b])
        );
    end

    for (genvar p = 0; p < NPADS; p++) begin : g_pad
        logic wr_here;
        assign wr_here = wr && in_pads && bank_open[bank] && (32'(idx) == p);
        pmx_pad_slot u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_l1 (wr_here && !bank),
            .wr_l2 (wr_here && bank),
            .wd_l1 ({bus_wdata[11:8], bus_wdata[3:0]}),
            .wd_l2 (bus_wdata[5:0]),
            .l1_q  (l1_q[p]),
            .l2_q  (l2_q[p]),
            .func  (func[p]),
            .hiz   (hiz_w[p])
        );
        assign pad_func[7*p +: 7]  = func[p];
        assign pad_pull[2*p +: 2]  = l1_q[p].pull;
        assign pad_drive[2*p +: 2] = l1_q[p].drive;
        assign pad_hiz[p]          = hiz_w[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdio_q[0] <= '0;
            mdio_q[1] <= '0;
        end else if (wr && is_mdio && bank_open[1]) begin
            mdio_q[bus_addr[3]] <= bus_wdata[2:0];
        end
    end
    assign mdio_sel = {mdio_q[1], mdio_q[0]};

    always_comb begin
        rd_val = '0;
        if (hit && !bus_we) begin
            if (in_pads) begin
                if (bank) rd_val = {26'd0, l2_q[idx]};
                else      rd_val = {20'd0, l1_q[idx].drive, l1_q[idx].pull, 4'd0, l1_q[idx].code};
            end else if (is_prot) begin
                rd_val = {bus_addr[31:1], bank_open[bank]};
            end else if (is_mdio) begin
                rd_val = {29'd0, mdio_q[bus_addr[3]]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            bus_err   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_sel;
            bus_err   <= lock_err;
            bus_rdata <= rd_val;
        end
    end
endmodule

// File: rtl/pmx_protect_chk.sv
module pmx_protect_chk #(
    parameter logic [31:0] BASE  = 32'h4000_0000,
    parameter int          NPADS = 170
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [31:0]        bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               bus_ready,
    input logic               bus_err,
    input logic [1:0]         bank_open,
    input logic [7*NPADS-1:0] pad_func,
    input logic [2*NPADS-1:0] pad_pull,
    input logic [2*NPADS-1:0] pad_drive,
    input logic [NPADS-1:0]   pad_hiz,
    input logic [5:0]         mdio_sel
);
    localparam logic [31:0] KEY0 = BASE + 32'h400;
    localparam logic [31:0] KEY1 = BASE + 32'hC00;

    // R5
    ready_follows_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> bus_ready);

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> (!bus_ready && !bus_err));

    // R4
    err_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ready);

    // R2
    open0_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_open[0]) |-> $past(bus_sel && bus_we && bus_addr == KEY0
                                      && bus_wdata == {KEY0[31:1], 1'b1}));

    // R3
    open1_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_open[1]) |-> $past(bus_sel && bus_we && bus_addr == KEY1
                                      && bus_wdata == {KEY1[31:1], 1'b1}));

    // R4
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_open == 2'b00) |=> ($stable(pad_func) && $stable(pad_pull)
                                  && $stable(pad_drive) && $stable(mdio_sel)));

    // R8
    hiz_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_hiz[0] == (pad_func[6:0] == 7'd0 || pad_func[6:0] == 7'd10));
endmodule

bind pmx_protect_bank pmx_protect_chk #(.BASE(BASE), .NPADS(NPADS)) u_protect_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .bus_err   (bus_err),
    .bank_open (bank_open),
    .pad_func  (pad_func),
    .pad_pull  (pad_pull),
    .pad_drive (pad_drive),
    .pad_hiz   (pad_hiz),
    .mdio_sel  (mdio_sel)
);

// File: tb/test_pmx_protect_bank.sv
module test_pmx_protect_bank;
    localparam int          CLK_PERIOD = 10;
    localparam int          NPADS  = 170;
    localparam logic [31:0] BASE_A = 32'h4000_0000;
    localparam logic [31:0] BASE_B = 32'h5000_3000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic ready_a, err_a, ready_b, err_b;
    logic [7*NPADS-1:0] func_a, func_b;
    logic [2*NPADS-1:0] pull_a, drive_a, pull_b, drive_b;
    logic [NPADS-1:0] hiz_a, hiz_b;
    logic [5:0] mdio_a, mdio_b;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [11:0] m_l1 [NPADS];
    logic [5:0]  m_l2 [NPADS];
    logic [2:0]  m_mdio [2];
    logic        m_open [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    pmx_protect_bank #(.BASE(BASE_A), .NPADS(NPADS)) i_pmx_protect_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
        .bus_ready(ready_a), .bus_err(err_a), .pad_func(func_a),
        .pad_pull(pull_a), .pad_drive(drive_a), .pad_hiz(hiz_a), .mdio_sel(mdio_a));

    pmx_protect_bank #(.BASE(BASE_B), .NPADS(NPADS)) i_pmx_protect_bank_b (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
        .bus_ready(ready_b), .bus_err(err_b), .pad_func(func_b),
        .pad_pull(pull_b), .pad_drive(drive_b), .pad_hiz(hiz_b), .mdio_sel(mdio_b));

    function automatic logic [6:0] exp_func(input logic [3:0] c, input logic [5:0] l2);
        if (c <= 4'd9) return {3'b0, c};
        if (c == 4'hF && l2 <= 6'd61) return 7'd10 + {1'b0, l2};
        return 7'h7F;
    endfunction

    function automatic logic exp_hiz(input logic [3:0] c, input logic [5:0] l2);
        return (c == 4'd0) || (c == 4'hF && l2 == 6'd0);
    endfunction

    function automatic logic [31:0] key_of(input int b);
        return BASE_A + 32'h400 + (b == 1 ? 32'h800 : 32'h0);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    logic [31:0] r_a, r_b;
    logic e_a, y_a;

    task automatic acc(input logic we, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        r_a = rdata_a; r_b = rdata_b; e_a = err_a; y_a = ready_a;
    endtask

    // model update for a write into window A
    task automatic model_wr(input logic [31:0] a, input logic [31:0] d, output logic exp_err);
        int b;
        int ix;
        logic [11:0] off;
        off = a[11:0];
        b = off[11];
        ix = int'(off[9:2]);
        exp_err = 1'b0;
        if (!off[10] && ix < NPADS) begin
            if (!m_open[b]) exp_err = 1'b1;
            else if (b == 0) m_l1[ix] = d[11:0] & 12'hF0F;
            else m_l2[ix] = d[5:0];
        end else if (off[10] && ix == 0) begin
            if (d[31:1] == key_of(b) >> 1) m_open[b] = d[0];
        end else if (b == 1 && off[10] && (ix == 1 || ix == 2)) begin
            if (!m_open[1]) exp_err = 1'b1;
            else m_mdio[ix - 1] = d[2:0];
        end
    endtask

    task automatic check_pad(input int p, input string req);
        chk(func_a[7*p +: 7] == exp_func(m_l1[p][3:0], m_l2[p]), req,
            32'(func_a[7*p +: 7]), 32'(exp_func(m_l1[p][3:0], m_l2[p])));
        chk(hiz_a[p] == exp_hiz(m_l1[p][3:0], m_l2[p]), "R8",
            32'(hiz_a[p]), 32'(exp_hiz(m_l1[p][3:0], m_l2[p])));
        chk(pull_a[2*p +: 2] == m_l1[p][9:8] && drive_a[2*p +: 2] == m_l1[p][11:10], "R9",
            {28'd0, drive_a[2*p +: 2], pull_a[2*p +: 2]}, {28'd0, m_l1[p][11:8]});
    endtask

    task automatic wr_a(input logic [31:0] off, input logic [31:0] d, input string req);
        logic ee;
        model_wr(BASE_A + off, d, ee);
        acc(1'b1, BASE_A + off, d);
        chk(e_a == ee && y_a, req, {30'd0, y_a, e_a}, {30'd0, 1'b1, ee});
    endtask

    task automatic rd_a(input logic [31:0] off, input logic [31:0] exp, input string req);
        acc(1'b0, BASE_A + off, 32'h0);
        chk(r_a == exp, req, r_a, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        for (int i = 0; i < NPADS; i++) begin m_l1[i] = '0; m_l2[i] = '0; end
        m_mdio[0] = '0; m_mdio[1] = '0; m_open[0] = 1'b0; m_open[1] = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!ready_a && !err_a, "R1", {30'd0, ready_a, err_a}, 32'd0);
        chk(func_a == '0 && pull_a == '0 && drive_a == '0 && mdio_a == '0, "R1", 32'(func_a[6:0]), 32'd0);
        chk(&hiz_a, "R1", 32'(hiz_a[31:0]), 32'hFFFF_FFFF);
        // R11 protect readback locked
        rd_a(32'h400, key_of(0), "R11");
        rd_a(32'hC00, key_of(1), "R11");
        // R5 ready timing
        chk(y_a, "R5", 32'(y_a), 32'd1);
        @(negedge clk);
        chk(!ready_a, "R5", 32'(ready_a), 32'd0);

        // R4 locked write refused
        wr_a(32'h014, 32'h0000_0F05, "R4");
        rd_a(32'h014, 32'h0, "R4");
        wr_a(32'hC04, 32'h5, "R4");
        chk(mdio_a == 6'd0, "R4", 32'(mdio_a), 32'd0);

        // R3 key with wrong upper bits, and a key written into B's window
        wr_a(32'h400, key_of(0) ^ 32'h0100_0001, "R3");
        rd_a(32'h400, key_of(0), "R3");
        acc(1'b1, BASE_B + 32'h400, key_of(0) | 32'h1);
        acc(1'b0, BASE_B + 32'h400, 32'h0);
        chk(r_b == BASE_B + 32'h400, "R3", r_b, BASE_B + 32'h400);
        acc(1'b1, BASE_B + 32'h400, (BASE_B + 32'h400) | 32'h1);
        acc(1'b0, BASE_B + 32'h400, 32'h0);
        chk(r_b == (BASE_B + 32'h401), "R2", r_b, BASE_B + 32'h401);
        rd_a(32'h400, key_of(0), "R3");

        // R2 unlock both halves of A
        wr_a(32'h400, key_of(0) | 32'h1, "R2");
        wr_a(32'hC00, key_of(1) | 32'h1, "R2");
        rd_a(32'h400, key_of(0) | 32'h1, "R2");

        // R6 layout
        wr_a(32'h000, 32'hFFFF_FFFF, "R6");
        rd_a(32'h000, 32'h0000_0F0F, "R6");
        wr_a(32'h800, 32'hFFFF_FFC0, "R6");
        rd_a(32'h800, 32'h0, "R6");
        check_pad(0, "R8");
        wr_a(32'h000, 32'h0000_060F, "R7");
        check_pad(0, "R7");
        wr_a(32'h004, 32'h0000_000C, "R7");
        check_pad(1, "R7");
        wr_a(32'h008, 32'h0000_000F, "R7");
        wr_a(32'h808, 32'h0000_003E, "R7");
        check_pad(2, "R7");
        wr_a(32'h808, 32'h0000_003D, "R7");
        check_pad(2, "R7");
        wr_a(32'h2A4, 32'h0000_0309, "R7");
        check_pad(169, "R7");
        // R11 unused offsets
        rd_a(32'h2A8, 32'h0, "R11");
        rd_a(32'h7FC, 32'h0, "R11");
        acc(1'b0, BASE_A + 32'h001, 32'h0);
        chk(r_a == 32'h0, "R11", r_a, 32'h0);
        // R10 MDIO
        wr_a(32'hC04, 32'hFFFF_FFFE, "R10");
        wr_a(32'hC08, 32'h0000_0003, "R10");
        rd_a(32'hC04, 32'h6, "R10");
        chk(mdio_a == {3'd3, 3'd6}, "R10", 32'(mdio_a), 32'(6'o36));

        // R12 independent locks
        wr_a(32'h400, key_of(0), "R12");
        wr_a(32'h010, 32'h0000_0001, "R12");
        wr_a(32'h810, 32'h0000_0007, "R12");
        rd_a(32'h810, 32'h7, "R12");
        rd_a(32'h010, 32'h0, "R12");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            int p;
            int b;
            op = int'($urandom % 10);
            p  = int'($urandom % NPADS);
            b  = int'($urandom % 2);
            if (op < 4) begin
                wr_a(32'(b * 32'h800 + p * 4), $urandom, b ? "R4" : "R6");
            end else if (op < 6) begin
                logic [31:0] k;
                k = key_of(b) | 32'($urandom % 2);
                if ($urandom % 4 == 0) k = k ^ (32'h1 << (1 + $urandom % 31));
                wr_a(key_of(b) - BASE_A, k, "R3");
            end else if (op == 6) begin
                int c;
                c = int'($urandom % 2);
                wr_a(32'hC04 + 32'(c * 4), $urandom, "R10");
                rd_a(32'hC04 + 32'(c * 4), {29'd0, m_mdio[c]}, "R10");
            end else if (op == 7) begin
                rd_a(key_of(b) - BASE_A, key_of(b) | 32'(m_open[b]), "R11");
            end else begin
                rd_a(32'(b * 32'h800 + p * 4),
                     b ? {26'd0, m_l2[p]} : {20'd0, m_l1[p]}, "R6");
            end
            check_pad(p, "R7");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule